// File: doc/BRIEF.md
# Bridge Control Registers and Interrupt Combiner

This block holds the control registers of a host-to-PCI bridge. They sit in a 4 KB control window. There are two of them. The first is a byte-order mode register: writing the code 0x02 to it reverses the byte lanes of every 32-bit word on the bridge data path. The reversal applies to host-to-PCI data and to PCI-to-host data alike. The second is an interrupt enable register. It gates one host interrupt line, and that line is formed from all the PCI interrupt request lines together.

The host reaches the registers over a simple request/acknowledge bus. The lane swap is purely combinational, so it adds no latency to data transfers. The PCI request lines are active-low and asynchronous. Each one passes through a two-flop synchroniser, the synchronised lines are OR-combined, and the result is gated by the enable. The host interrupt output is registered. No acknowledge register exists: the output stays high for as long as any source line is held low and the enable is set.

Top module: `brctl_top`

## Requirements
- R1: After reset, host_irq and reg_ack are 0. The mode register reads 0x00 and the interrupt enable register reads 0x00.
- R2: A write to byte offset 0x000 stores wdata[7:0] in the mode register. A read of offset 0x000 returns the stored value in bits 7:0, with bits 31:8 zero.
- R3: A write to byte offset 0x010 stores wdata[7:0] in the interrupt enable register. A read returns that value in bits 7:0, with bits 31:8 zero. Bit 0 of the stored value is the enable.
- R4: A read of any offset other than 0x000 or 0x010 returns zero. A write to any such offset changes neither register.
- R5: When the mode register holds 0x02, pci_wdata is host_wdata with bytes 0..3 reversed (byte 0 = bits 7:0), and host_rdata is pci_rdata with its bytes reversed the same way. Both paths are combinational.
- R6: For any mode value other than 0x02, pci_wdata equals host_wdata and host_rdata equals pci_rdata.
- R7: reg_ack is 1 in the cycle after each cycle in which reg_req is sampled high, and 0 otherwise. Read data is valid while reg_ack is 1. A write takes effect at the edge where the request is sampled.
- R8: With the enable set, host_irq is 1 three clock edges after any pci_int_n line goes low. That delay is two synchroniser stages plus the output register.
- R9: While enable bit 0 is 0, host_irq is 0. host_irq changes one clock after the enable register is written.
- R10: host_irq stays 1 while any line is held low, because no acknowledge exists. It returns to 0 three edges after the last low line goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset in the control window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_ack |
| reg_ack | output | 1 | Access acknowledge |
| host_wdata | input | 32 | Data from host toward PCI |
| pci_wdata | output | 32 | Lane-ordered data toward PCI |
| pci_rdata | input | 32 | Data from PCI toward host |
| host_rdata | output | 32 | Lane-ordered data toward host |
| pci_int_n | input | 4 | PCI interrupt requests, active-low |
| host_irq | output | 1 | Combined, gated host interrupt, active-high |

## Verification
A corrupted mode register shows up at once on both data paths, because the swap is combinational: the byte order is wrong in the same cycle. It also shows up on the next register read. A wrong enable bit or a stuck synchroniser stage shows up on host_irq. The output then rises or falls at the wrong edge, or fails to follow the source lines, within three cycles of the stimulus. The bench samples at exactly those edges so that an off-by-one latency is caught.

// File: rtl/brctl_pkg.sv
package brctl_pkg;
  localparam int          WIN_ADDR_W = 12;
  localparam int          CTRL_W     = 8;
  localparam logic [11:0] OFF_ORDER  = 12'h000;
  localparam logic [11:0] OFF_IRQEN  = 12'h010;
  localparam logic [7:0]  ORDER_BIG  = 8'h02;

  // Full-offset match of a window address.
  function automatic logic hit(input logic [WIN_ADDR_W-1:0] a,
                               input logic [WIN_ADDR_W-1:0] off);
    return a == off;
  endfunction

  // Byte-order code to swap decision.
  function automatic logic order_swaps(input logic [CTRL_W-1:0] code);
    return code == ORDER_BIG;
  endfunction
endpackage

// File: rtl/brctl_regs.sv
module brctl_regs
  import brctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [WIN_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  ack,
  output logic [CTRL_W-1:0]     order_q,
  output logic [CTRL_W-1:0]     irqen_q
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic sel_order, sel_irqen;
  logic [CTRL_W-1:0] rd_byte;
  logic unused_wdata_hi;

  assign sel_order       = hit(addr, OFF_ORDER);
  assign sel_irqen       = hit(addr, OFF_IRQEN);
  assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

  always_comb begin
    rd_byte = '0;
    if (sel_order)      rd_byte = order_q;
    else if (sel_irqen) rd_byte = irqen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= '0;
      irqen_q <= '0;
    end else if (req && we) begin
      if (sel_order) order_q <= wdata[CTRL_W-1:0];
      if (sel_irqen) irqen_q <= wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      rdata <= (req && !we) ? {{PAD_W{1'b0}}, rd_byte} : '0;
    end
  end
endmodule

// File: rtl/brctl_swap.sv
module brctl_swap #(
  parameter int DATA_W = 32
) (
  input  logic              swap_en,
  input  logic [DATA_W-1:0] down_in,
  output logic [DATA_W-1:0] down_out,
  input  logic [DATA_W-1:0] up_in,
  output logic [DATA_W-1:0] up_out
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] down_rev, up_rev;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign down_rev[8*g +: 8] = down_in[8*(LANES-1-g) +: 8];
    assign up_rev[8*g +: 8]   = up_in[8*(LANES-1-g) +: 8];
  end

  assign down_out = swap_en ? down_rev : down_in;
  assign up_out   = swap_en ? up_rev   : up_in;
endmodule

// File: rtl/brctl_irq.sv
module brctl_irq #(
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_n,
  input  logic               enable,
  output logic               any_req,
  output logic               irq_out
);
  logic [NUM_INT-1:0] stage [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '1;
      else if (s == 0) stage[s] <= int_n;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign any_req = |(~stage[SYNC_STAGES-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= any_req & enable;
  end
endmodule

// File: rtl/brctl_top.sv
module brctl_top
  import brctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_req,
  input  logic                  reg_we,
  input  logic [WIN_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  reg_ack,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic [DATA_W-1:0]     pci_wdata,
  input  logic [DATA_W-1:0]     pci_rdata,
  output logic [DATA_W-1:0]     host_rdata,
  input  logic [NUM_INT-1:0]    pci_int_n,
  output logic                  host_irq
);
  logic [CTRL_W-1:0] order_q, irqen_q;
  logic swap_active, irq_enabled, irq_pending;
  logic unused_irqen_hi;

  assign swap_active     = order_swaps(order_q);
  assign irq_enabled     = irqen_q[0];
  assign unused_irqen_hi = ^irqen_q[CTRL_W-1:1];

  brctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ack(reg_ack),
    .order_q(order_q), .irqen_q(irqen_q)
  );

  brctl_swap #(.DATA_W(DATA_W)) u_swap (
    .swap_en(swap_active),
    .down_in(host_wdata), .down_out(pci_wdata),
    .up_in(pci_rdata),    .up_out(host_rdata)
  );

  brctl_irq #(.NUM_INT(NUM_INT), .SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_n), .int_n(pci_int_n), .enable(irq_enabled),
    .any_req(irq_pending), .irq_out(host_irq)
  );
endmodule

// File: rtl/brctl_checker.sv
module brctl_checker #(
  parameter int DATA_W  = 32,
  parameter int NUM_INT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_req,
  input logic               reg_ack,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  pci_wdata,
  input logic [DATA_W-1:0]  pci_rdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic [NUM_INT-1:0] pci_int_n,
  input logic               host_irq,
  input logic               swap_active,
  input logic               irq_enabled,
  input logic               irq_pending
);
  localparam int LANES = DATA_W / 8;

  assert_ack_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_ack);
  assert_no_spurious_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> !reg_ack);
  assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |-> (reg_rdata[DATA_W-1:8] == '0));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(irq_enabled));
  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !(&$past(pci_int_n, 3)));
  assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && irq_enabled) |=> host_irq);
  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_active |-> (pci_wdata == host_wdata && host_rdata == pci_rdata));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_lane_rev_R5: assert property (@(posedge clk) disable iff (!rst_n)
      swap_active |-> (pci_wdata[8*g +: 8] == host_wdata[DATA_W-8-8*g +: 8] &&
                       host_rdata[8*g +: 8] == pci_rdata[DATA_W-8-8*g +: 8]));
  end
endmodule

bind brctl_top brctl_checker #(.DATA_W(DATA_W), .NUM_INT(NUM_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_ack(reg_ack),
  .reg_rdata(reg_rdata), .host_wdata(host_wdata), .pci_wdata(pci_wdata),
  .pci_rdata(pci_rdata), .host_rdata(host_rdata), .pci_int_n(pci_int_n),
  .host_irq(host_irq), .swap_active(swap_active), .irq_enabled(irq_enabled),
  .irq_pending(irq_pending)
);

// File: tb/test_brctl_top.sv
module test_brctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_ack;
  logic [31:0] host_wdata = '0, pci_wdata, pci_rdata = '0, host_rdata;
  logic [3:0]  pci_int_n = 4'hF;
  logic        host_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brctl_top i_brctl_top (.*);

  localparam int NV = 6;
  localparam logic [7:0]  MODE_V [NV] = '{8'h00, 8'h02, 8'h01, 8'h03, 8'h02, 8'hFF};
  localparam logic [31:0] DATA_V [NV] = '{32'h11223344, 32'hA1B2C3D4, 32'hDEADBEEF,
                                          32'h00FF00FF, 32'h80000001, 32'h76543210};

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    chk("R7 write ack", {31'b0, reg_ack}, 32'd1);
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req = 0;
    chk("R7 read ack", {31'b0, reg_ack}, 32'd1);
    d = reg_rdata;
    @(negedge clk);
    chk("R7 ack drops", {31'b0, reg_ack}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_irq", {31'b0, host_irq}, 0);
    chk("R1 reg_ack", {31'b0, reg_ack}, 0);
    bus_read(12'h000, rd); chk("R1 mode reset", rd, 32'h0);
    bus_read(12'h010, rd); chk("R1 irqen reset", rd, 32'h0);

    // Vector table: mode value, then data both directions (R5/R6)
    for (int i = 0; i < NV; i++) begin
      bus_write(12'h000, {24'hABCDEF, MODE_V[i]});
      bus_read(12'h000, rd);
      chk("R2 mode readback", rd, {24'h0, MODE_V[i]});
      @(negedge clk);
      host_wdata = DATA_V[i];
      pci_rdata  = ~DATA_V[i];
      #1;
      if (MODE_V[i] == 8'h02) begin
        chk("R5 down swap", pci_wdata, rev(DATA_V[i]));
        chk("R5 up swap", host_rdata, rev(~DATA_V[i]));
      end else begin
        chk("R6 down pass", pci_wdata, DATA_V[i]);
        chk("R6 up pass", host_rdata, ~DATA_V[i]);
      end
    end

    // R3 enable register
    bus_write(12'h010, 32'hFFFF_FF5A);
    bus_read(12'h010, rd); chk("R3 irqen readback", rd, 32'h5A);

    // R4 unmapped offsets
    bus_write(12'h000, 32'h02);
    bus_write(12'h004, 32'h77);
    bus_write(12'h011, 32'h01);
    bus_write(12'hFF0, 32'h33);
    bus_read(12'h004, rd); chk("R4 unmapped read", rd, 32'h0);
    bus_read(12'h020, rd); chk("R4 unmapped read hi", rd, 32'h0);
    bus_read(12'h000, rd); chk("R4 mode untouched", rd, 32'h02);
    bus_read(12'h010, rd); chk("R4 irqen untouched", rd, 32'h5A);

    // R9: enable bit 0 clear, line low -> no irq
    bus_write(12'h010, 32'h00);
    @(negedge clk); pci_int_n = 4'b1101;
    repeat (5) @(negedge clk);
    chk("R9 gated off", {31'b0, host_irq}, 0);
    // enable written: irq one cycle after write edge
    bus_write(12'h010, 32'h01);
    chk("R9 not yet", {31'b0, host_irq}, 0);
    @(negedge clk);
    chk("R9 enable follows", {31'b0, host_irq}, 1);
    // R10 hold while low, and through a second line
    pci_int_n = 4'b0101;
    repeat (4) @(negedge clk);
    chk("R10 held", {31'b0, host_irq}, 1);
    pci_int_n = 4'b0111;
    repeat (4) @(negedge clk);
    chk("R10 still held", {31'b0, host_irq}, 1);
    pci_int_n = 4'b1111;
    @(negedge clk); @(negedge clk);
    chk("R10 release latency", {31'b0, host_irq}, 1);
    @(negedge clk);
    chk("R10 released", {31'b0, host_irq}, 0);
    // R8 latency from a single line
    pci_int_n = 4'b0111;
    @(negedge clk); @(negedge clk);
    chk("R8 before 3 edges", {31'b0, host_irq}, 0);
    @(negedge clk);
    chk("R8 at 3 edges", {31'b0, host_irq}, 1);
    // disable drops next cycle
    bus_write(12'h010, 32'h00);
    chk("R9 disable at edge+1", {31'b0, host_irq}, 1);
    @(negedge clk);
    chk("R9 disabled", {31'b0, host_irq}, 0);
    pci_int_n = 4'hF;

    // R1 again after mid-run reset
    bus_write(12'h000, 32'h02);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    bus_read(12'h000, rd); chk("R1 mode after reset", rd, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule